// File: doc/BRIEF.md
# Scan-Com Register Bridge

The bridge sits between a host that issues 64-bit register accesses into an address window and an internal register bus. Each host address is turned into a compact register index using one of two translation modes. The mode is picked by a configuration pin that is captured while reset is held.

A small fixed set of housekeeping indexes is served inside the bridge. Those reads return a chip identification constant or zero. Writes to those indexes are discarded. Every other access goes out as one request on the downstream bus, at byte address index × 8. The host is held busy until the downstream side acknowledges the request, or until a programmable timeout expires.

Each access ends with a one-cycle response pulse and sets a sticky done flag. An access that failed also sets a sticky fail flag. An access fails when it is not a full aligned 64-bit access, when the downstream side reports an error, or when the timeout expires. Software clears the two flags through a separate write-one-to-clear status port.

Top module: `scom_bridge`

## Requirements
- R1: In translation mode A (cfgModeB low at reset) the index is hostAddr >> 3. A forwarded access drives dsAddr = index << 3, which is hostAddr with bits 2:0 cleared.
- R2: In translation mode B (cfgModeB high at reset) the index is ((hostAddr >> 4) with bits 3:0 cleared) OR ((hostAddr >> 3) AND 0xF). Host address bit 7 is therefore ignored. A forwarded access drives dsAddr = index << 3.
- R3: The translation mode is captured only while rstN is low. Changing cfgModeB after reset has no effect on translation.
- R4: Host data lanes are big-endian. Byte k of the host data (bits 63-8k down to 56-8k) is byte 7-k of the internal value. The same reversal applies to dsWdata from hostWdata and to hostRdata from dsRdata.
- R5: A read of index 0xF000F returns the CHIP_ID parameter in host byte order, with no downstream request. A write to 0xF000F makes no downstream request.
- R6: Reads of the following indexes return zero, set only done, and make no downstream request: 0x18002, 0x1010C00, 0x1010C03, 0x1020013, 0x1020014, 0xF0033, 0xF0034, 0x90012, 0x90013, 0x90018, 0x2020007, 0x2020009, 0x202000F, and 0x2013F00 through 0x2013F07.
- R7: Writes to the following indexes are dropped with no downstream request, and set only done: 0xF000F, 0x1010C00 through 0x1010C05, 0x1020013, 0x1020014, 0xF0033, 0xF0034, 0x90012, 0x90013, 0x90018, 0x2020007, 0x2020009, 0x202000F.
- R8: Every other access is forwarded. This includes reads of 0x1010C01, 0x1010C02, 0x1010C04 and 0x1010C05, and writes to 0x18002 and 0x2013F00 through 0x2013F07.
- R9: An access with hostByteEn other than 8'hFF, or with hostAddr bits 2:0 nonzero, makes no downstream request. It sets both done and fail, and returns zero read data.
- R10: A downstream acknowledge with dsErr high sets both done and fail, and the response carries zero read data.
- R11: dsReq stays high, with dsAddr, dsWrite and dsWdata stable, until dsAck. An acknowledge within the first cfgTimeout+1 request cycles completes normally. With no acknowledge, dsReq drops after exactly cfgTimeout+1 cycles and the access fails like R10.
- R12: statusDone and statusFail are zero after reset and sticky. Writing statusWe with a 1 in statusClr bit 0 clears done, and a 1 in bit 1 clears fail. A completion in the same cycle as a clear wins. Successful and locally served accesses set only done.
- R13: hostReady is high only when no access is in flight. hostRespValid pulses for one cycle per accepted access, and no downstream request is active while hostReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgModeB | input | 1 | Translation mode select, captured during reset |
| cfgTimeout | input | TMO_W | Downstream wait limit in cycles, minus one |
| hostValid | input | 1 | Host access request |
| hostReady | output | 1 | Bridge idle, request accepted this cycle |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostByteEn | input | 8 | Byte enables, must be all ones |
| hostAddr | input | WIN_W | Byte offset within the register window |
| hostWdata | input | 64 | Write data, big-endian lanes |
| hostRespValid | output | 1 | One-cycle completion pulse |
| hostRdata | output | 64 | Read data, big-endian lanes, valid with hostRespValid |
| dsReq | output | 1 | Downstream request, held until acknowledge or timeout |
| dsWrite | output | 1 | Downstream direction |
| dsAddr | output | WIN_W | Downstream byte address (index << 3) |
| dsWdata | output | 64 | Downstream write data |
| dsAck | input | 1 | Downstream acknowledge |
| dsErr | input | 1 | Downstream error, qualified by dsAck |
| dsRdata | input | 64 | Downstream read data, qualified by dsAck |
| statusWe | input | 1 | Status clear strobe |
| statusClr | input | 2 | Write-one-to-clear mask: bit 0 done, bit 1 fail |
| statusDone | output | 1 | Sticky done flag |
| statusFail | output | 1 | Sticky fail flag |

## Verification
Addresses built from the housekeeping indexes are run through both translation modes. In mode B, address bit 7 is set at random, which shows whether the ignored bit leaks into the index and separates local service from forwarding by direction. Random aligned addresses with random data, latency and error injection check the forwarding path, the dsAddr scramble and the lane reversal against bench models. Malformed byte enables and misaligned offsets check rejection. Directed runs cover the timeout edge (an acknowledge on the last allowed cycle against no acknowledge at all), a mode pin toggled after reset, partial status clears, and a clear that collides with a completion.

// File: rtl/scom_pkg.sv
package scom_pkg;

  typedef enum logic [1:0] {
    RD_ZERO  = 2'd0,
    RD_LOCAL = 2'd1,
    RD_DS    = 2'd2
  } rdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   capture;
    logic   finish;
    logic   finFail;
    rdSel_e rdSel;
  } scomStb_t;

  localparam logic [31:0] IDX_CHIP = 32'h000F_000F;

  function automatic logic [63:0] byteSwap64(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = v[8*(7-i) +: 8];
    return r;
  endfunction

  // housekeeping indexes shared by the read and write lists
  function automatic logic isHkCommon(input logic [31:0] idx);
    case (idx)
      32'h0102_0013, 32'h0102_0014, 32'h000F_0033, 32'h000F_0034,
      32'h0009_0012, 32'h0009_0013, 32'h0009_0018,
      32'h0202_0007, 32'h0202_0009, 32'h0202_000F: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic isZeroRead(input logic [31:0] idx);
    logic hit;
    hit = isHkCommon(idx);
    if (idx == 32'h0001_8002 || idx == 32'h0101_0C00 || idx == 32'h0101_0C03) hit = 1'b1;
    if (idx[31:3] == 29'h0040_27E0) hit = 1'b1;  // 0x2013F00..0x2013F07
    return hit;
  endfunction

  function automatic logic isDropWrite(input logic [31:0] idx);
    logic hit;
    hit = isHkCommon(idx) || (idx == IDX_CHIP);
    if (idx >= 32'h0101_0C00 && idx <= 32'h0101_0C05) hit = 1'b1;
    return hit;
  endfunction

endpackage

// File: rtl/scom_xlate.sv
module scom_xlate
  import scom_pkg::*;
#(
  parameter int WIN_W = 32,
  parameter int IDX_W = WIN_W - 3
) (
  input  logic [WIN_W-1:0] addr,
  input  logic             modeB,
  output logic [IDX_W-1:0] idx,
  output logic             aligned,
  output logic             chipHit,
  output logic             zeroRead,
  output logic             dropWrite
);

  logic [IDX_W-1:0] idxA;
  logic [IDX_W-1:0] idxB;
  logic [31:0]      idx32;

  assign idxA = addr[WIN_W-1:3];

  // mode B: low nibble from addr[6:3], upper index bits from addr[WIN_W-1:8]
  assign idxB[3:0] = addr[6:3];
  generate
    for (genvar k = 4; k <= IDX_W - 2; k++) begin : g_scr
      assign idxB[k] = addr[k+4];
    end
  endgenerate
  assign idxB[IDX_W-1] = 1'b0;

  assign idx     = modeB ? idxB : idxA;
  assign aligned = (addr[2:0] == 3'b000);

  generate
    if (IDX_W >= 32) begin : g_wide
      assign idx32 = idx[31:0];
    end else begin : g_narrow
      assign idx32 = {{(32-IDX_W){1'b0}}, idx};
    end
  endgenerate

  assign chipHit   = (idx32 == IDX_CHIP);
  assign zeroRead  = isZeroRead(idx32);
  assign dropWrite = isDropWrite(idx32);

endmodule

// File: rtl/scom_dpath.sv
module scom_dpath
  import scom_pkg::*;
#(
  parameter int          WIN_W   = 32,
  parameter logic [63:0] CHIP_ID = 64'h0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgModeB,
  input  scomStb_t         stb,
  input  logic             hostWrite,
  input  logic [7:0]       hostByteEn,
  input  logic [WIN_W-1:0] hostAddr,
  input  logic [63:0]      hostWdata,
  input  logic [63:0]      dsRdata,
  input  logic             statusWe,
  input  logic [1:0]       statusClr,
  output logic             lookBad,
  output logic             lookLocal,
  output logic             dsWrite,
  output logic [WIN_W-1:0] dsAddr,
  output logic [63:0]      dsWdata,
  output logic             hostRespValid,
  output logic [63:0]      hostRdata,
  output logic             statusDone,
  output logic             statusFail
);

  localparam int IDX_W = WIN_W - 3;

  logic             modeReg;
  logic [IDX_W-1:0] xlIdx;
  logic             xlAligned, xlChip, xlZero, xlDrop;

  logic [IDX_W-1:0] idxReg;
  logic             wrReg, badReg, chipReg, zeroReg, dropReg;
  logic [63:0]      wdataReg;

  // mode pin is loaded only while reset is asserted
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeReg <= cfgModeB;
    else       modeReg <= modeReg;
  end

  scom_xlate #(.WIN_W(WIN_W), .IDX_W(IDX_W)) u_xlate (
    .addr     (hostAddr),
    .modeB    (modeReg),
    .idx      (xlIdx),
    .aligned  (xlAligned),
    .chipHit  (xlChip),
    .zeroRead (xlZero),
    .dropWrite(xlDrop)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg   <= '0;
      wrReg    <= 1'b0;
      badReg   <= 1'b0;
      chipReg  <= 1'b0;
      zeroReg  <= 1'b0;
      dropReg  <= 1'b0;
      wdataReg <= '0;
    end else if (stb.capture) begin
      idxReg   <= xlIdx;
      wrReg    <= hostWrite;
      badReg   <= !xlAligned || (hostByteEn != 8'hFF);
      chipReg  <= xlChip;
      zeroReg  <= xlZero;
      dropReg  <= xlDrop;
      wdataReg <= hostWdata;
    end
  end

  assign lookBad   = badReg;
  assign lookLocal = wrReg ? dropReg : (zeroReg || chipReg);

  assign dsWrite = wrReg;
  assign dsAddr  = {idxReg, 3'b000};
  assign dsWdata = byteSwap64(wdataReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRespValid <= 1'b0;
      hostRdata     <= '0;
    end else begin
      hostRespValid <= stb.finish;
      if (stb.finish) begin
        if (wrReg) begin
          hostRdata <= '0;
        end else begin
          case (stb.rdSel)
            RD_LOCAL: hostRdata <= chipReg ? byteSwap64(CHIP_ID) : 64'h0;
            RD_DS:    hostRdata <= byteSwap64(dsRdata);
            default:  hostRdata <= '0;
          endcase
        end
      end
    end
  end

  // sticky flags, completion wins over a coincident clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusDone <= 1'b0;
      statusFail <= 1'b0;
    end else begin
      statusDone <= (statusDone && !(statusWe && statusClr[0])) || stb.finish;
      statusFail <= (statusFail && !(statusWe && statusClr[1])) || (stb.finish && stb.finFail);
    end
  end

endmodule

// File: rtl/scom_ctrl.sv
module scom_ctrl
  import scom_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TMO_W-1:0] cfgTimeout,
  input  logic             hostValid,
  input  logic             lookBad,
  input  logic             lookLocal,
  input  logic             dsAck,
  input  logic             dsErr,
  output logic             hostReady,
  output logic             dsReq,
  output scomStb_t         stb
);

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_WAIT} state_e;

  state_e           state, stateNxt;
  logic [TMO_W-1:0] waitCnt;
  logic             expired;

  assign hostReady = (state == S_IDLE);
  assign dsReq     = (state == S_WAIT);
  assign expired   = (waitCnt == cfgTimeout);

  always_comb begin
    stateNxt    = state;
    stb         = '0;
    stb.rdSel   = RD_ZERO;
    case (state)
      S_IDLE: begin
        if (hostValid) begin
          stb.capture = 1'b1;
          stateNxt    = S_LOOK;
        end
      end
      S_LOOK: begin
        if (lookBad) begin
          stb.finish  = 1'b1;
          stb.finFail = 1'b1;
          stateNxt    = S_IDLE;
        end else if (lookLocal) begin
          stb.finish = 1'b1;
          stb.rdSel  = RD_LOCAL;
          stateNxt   = S_IDLE;
        end else begin
          stateNxt = S_WAIT;
        end
      end
      S_WAIT: begin
        if (dsAck) begin
          stb.finish  = 1'b1;
          stb.finFail = dsErr;
          stb.rdSel   = dsErr ? RD_ZERO : RD_DS;
          stateNxt    = S_IDLE;
        end else if (expired) begin
          stb.finish  = 1'b1;
          stb.finFail = 1'b1;
          stateNxt    = S_IDLE;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
    end else begin
      state <= stateNxt;
      if (state == S_WAIT) waitCnt <= waitCnt + 1'b1;
      else                 waitCnt <= '0;
    end
  end

endmodule

// File: rtl/scom_bridge.sv
module scom_bridge
  import scom_pkg::*;
#(
  parameter int          WIN_W   = 32,
  parameter int          TMO_W   = 8,
  parameter logic [63:0] CHIP_ID = 64'h0000_0042_D00D_F00D
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgModeB,
  input  logic [TMO_W-1:0] cfgTimeout,
  input  logic             hostValid,
  output logic             hostReady,
  input  logic             hostWrite,
  input  logic [7:0]       hostByteEn,
  input  logic [WIN_W-1:0] hostAddr,
  input  logic [63:0]      hostWdata,
  output logic             hostRespValid,
  output logic [63:0]      hostRdata,
  output logic             dsReq,
  output logic             dsWrite,
  output logic [WIN_W-1:0] dsAddr,
  output logic [63:0]      dsWdata,
  input  logic             dsAck,
  input  logic             dsErr,
  input  logic [63:0]      dsRdata,
  input  logic             statusWe,
  input  logic [1:0]       statusClr,
  output logic             statusDone,
  output logic             statusFail
);

  scomStb_t stb;
  logic     lookBad, lookLocal;

  scom_ctrl #(.TMO_W(TMO_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgTimeout(cfgTimeout),
    .hostValid (hostValid),
    .lookBad   (lookBad),
    .lookLocal (lookLocal),
    .dsAck     (dsAck),
    .dsErr     (dsErr),
    .hostReady (hostReady),
    .dsReq     (dsReq),
    .stb       (stb)
  );

  scom_dpath #(.WIN_W(WIN_W), .CHIP_ID(CHIP_ID)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .cfgModeB     (cfgModeB),
    .stb          (stb),
    .hostWrite    (hostWrite),
    .hostByteEn   (hostByteEn),
    .hostAddr     (hostAddr),
    .hostWdata    (hostWdata),
    .dsRdata      (dsRdata),
    .statusWe     (statusWe),
    .statusClr    (statusClr),
    .lookBad      (lookBad),
    .lookLocal    (lookLocal),
    .dsWrite      (dsWrite),
    .dsAddr       (dsAddr),
    .dsWdata      (dsWdata),
    .hostRespValid(hostRespValid),
    .hostRdata    (hostRdata),
    .statusDone   (statusDone),
    .statusFail   (statusFail)
  );

endmodule

// File: rtl/scom_bridge_chk.sv
module scom_bridge_chk #(
  parameter int WIN_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostValid,
  input logic             hostReady,
  input logic             hostRespValid,
  input logic [63:0]      hostRdata,
  input logic             dsReq,
  input logic             dsWrite,
  input logic [WIN_W-1:0] dsAddr,
  input logic [63:0]      dsWdata,
  input logic             dsAck,
  input logic             dsErr,
  input logic             statusDone,
  input logic             statusFail
);

  p_accept_busy_r13: assert property (@(posedge clk) disable iff (!rstN)
    hostValid && hostReady |=> !hostReady);

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |-> !dsReq);

  p_resp_idle_r13: assert property (@(posedge clk) disable iff (!rstN)
    hostRespValid |-> hostReady);

  p_ds_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    dsReq && !dsAck |=> $stable(dsAddr) && $stable(dsWrite) && $stable(dsWdata));

  p_ds_err_r10: assert property (@(posedge clk) disable iff (!rstN)
    dsReq && dsAck && dsErr |=> hostRespValid && (hostRdata == 64'h0) && statusFail && statusDone);

  p_ds_ok_r12: assert property (@(posedge clk) disable iff (!rstN)
    dsReq && dsAck && !dsErr |=> hostRespValid && statusDone);

  p_resp_done_r12: assert property (@(posedge clk) disable iff (!rstN)
    hostRespValid |-> statusDone);

endmodule

bind scom_bridge scom_bridge_chk #(.WIN_W(WIN_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .hostValid    (hostValid),
  .hostReady    (hostReady),
  .hostRespValid(hostRespValid),
  .hostRdata    (hostRdata),
  .dsReq        (dsReq),
  .dsWrite      (dsWrite),
  .dsAddr       (dsAddr),
  .dsWdata      (dsWdata),
  .dsAck        (dsAck),
  .dsErr        (dsErr),
  .statusDone   (statusDone),
  .statusFail   (statusFail)
);

// File: tb/sim_scom_bridge.sv
`timescale 1ns/1ps
module sim_scom_bridge;

  localparam int          WIN_W   = 32;
  localparam int          TMO_W   = 8;
  localparam logic [63:0] CHIP_ID = 64'h1357_9BDF_0246_8ACE;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgModeB = 1'b0;
  logic [TMO_W-1:0] cfgTimeout = 8'd20;
  logic             hostValid = 1'b0, hostWrite = 1'b0;
  logic             hostReady;
  logic [7:0]       hostByteEn = 8'hFF;
  logic [WIN_W-1:0] hostAddr = '0;
  logic [63:0]      hostWdata = '0;
  logic             hostRespValid;
  logic [63:0]      hostRdata;
  logic             dsReq, dsWrite;
  logic [WIN_W-1:0] dsAddr;
  logic [63:0]      dsWdata;
  logic             dsAck = 1'b0, dsErr = 1'b0;
  logic [63:0]      dsRdata = '0;
  logic             statusWe = 1'b0;
  logic [1:0]       statusClr = 2'b00;
  logic             statusDone, statusFail;

  always #10 clk = ~clk;

  scom_bridge #(.WIN_W(WIN_W), .TMO_W(TMO_W), .CHIP_ID(CHIP_ID)) u0 (.*);

  int checks = 0, failures = 0;
  bit curModeB = 1'b0;

  // downstream responder state
  bit          respOn = 1'b1, respErr = 1'b0;
  int          respLat = 0, lat = 0, dsCount = 0, reqCycles = 0;
  logic [31:0] lastAddr;
  logic        lastW;
  logic [63:0] lastWd;

  function automatic logic [63:0] swap(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = v[8*(7-i) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] model(input logic [31:0] a);
    return {a ^ 32'hA5C3_9E10, ~a};
  endfunction

  function automatic logic [31:0] toIdx(input logic [31:0] a, input bit mb);
    if (mb) return ((a >> 4) & ~32'hF) | ((a >> 3) & 32'hF);
    return a >> 3;
  endfunction

  function automatic logic [31:0] fromIdx(input logic [31:0] idx, input bit mb, input bit b7);
    if (mb) return ((idx >> 4) << 8) | (32'(b7) << 7) | ((idx & 32'hF) << 3);
    return idx << 3;
  endfunction

  function automatic bit commonHk(input logic [31:0] i);
    return i == 32'h1020013 || i == 32'h1020014 || i == 32'hF0033 || i == 32'hF0034 ||
           i == 32'h90012 || i == 32'h90013 || i == 32'h90018 ||
           i == 32'h2020007 || i == 32'h2020009 || i == 32'h202000F;
  endfunction

  function automatic bit expZeroRd(input logic [31:0] i);
    return commonHk(i) || i == 32'h18002 || i == 32'h1010C00 || i == 32'h1010C03 ||
           (i >= 32'h2013F00 && i <= 32'h2013F07);
  endfunction

  function automatic bit expDropWr(input logic [31:0] i);
    return commonHk(i) || i == 32'hF000F || (i >= 32'h1010C00 && i <= 32'h1010C05);
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (dsReq && !dsAck) begin
      reqCycles++;
      if (lat == 0) begin
        dsCount++;
        lastAddr = dsAddr;
        lastW    = dsWrite;
        lastWd   = dsWdata;
      end
      if (respOn && lat == respLat) begin
        dsAck   = 1'b1;
        dsErr   = respErr;
        dsRdata = model(dsAddr);
      end
      lat++;
    end else begin
      dsAck = 1'b0;
      dsErr = 1'b0;
      lat   = 0;
    end
  end

  task automatic doReset(input bit mb);
    @(negedge clk);
    rstN = 1'b0;
    cfgModeB = mb;
    curModeB = mb;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic clearStatus(input logic [1:0] m);
    statusWe = 1'b1;
    statusClr = m;
    @(negedge clk);
    statusWe = 1'b0;
    statusClr = 2'b00;
  endtask

  task automatic runOne(input string req, input bit wr, input logic [7:0] be, input logic [31:0] addr,
                        input logic [63:0] wd, input bit err, input int latency, input bit doClr);
    logic [31:0] idx;
    bit bad, loc, expDs, expFail, got;
    logic [63:0] expRd, rd;
    idx     = toIdx(addr, curModeB);
    bad     = (be != 8'hFF) || (addr[2:0] != 3'b000);
    loc     = bad || (wr ? expDropWr(idx) : (idx == 32'hF000F || expZeroRd(idx)));
    expDs   = !loc;
    expFail = bad || (expDs && (err || !respOn));
    if (wr || expFail) expRd = 64'h0;
    else if (loc)      expRd = (idx == 32'hF000F) ? swap(CHIP_ID) : 64'h0;
    else               expRd = swap(model(idx << 3));
    respErr = err;
    respLat = latency;
    dsCount = 0;
    reqCycles = 0;
    hostValid = 1'b1; hostWrite = wr; hostByteEn = be; hostAddr = addr; hostWdata = wd;
    @(negedge clk);
    hostValid = 1'b0;
    got = 1'b0;
    rd = '0;
    for (int i = 0; i < 300; i++) begin
      if (hostRespValid) begin got = 1'b1; rd = hostRdata; break; end
      @(negedge clk);
    end
    check(req, "response seen", 64'(got), 64'h1);
    check(req, "downstream count", 64'(dsCount), 64'(expDs));
    if (expDs) begin
      check(req, "dsAddr", 64'(lastAddr), 64'(idx << 3));
      check(req, "dsWrite", 64'(lastW), 64'(wr));
      if (wr) check(req, "dsWdata", lastWd, swap(wd));
      check(req, "request cycles", 64'(reqCycles), respOn ? 64'(latency + 1) : 64'(cfgTimeout) + 64'd1);
    end
    check(req, "hostRdata", rd, expRd);
    check(req, "statusDone", 64'(statusDone), 64'h1);
    if (doClr || expFail) check(req, "statusFail", 64'(statusFail), 64'(expFail));
    @(negedge clk);
    check(req, "respValid one cycle", 64'(hostRespValid), 64'h0);
    if (doClr) begin
      clearStatus(2'b11);
      check("R12", "status cleared", {62'h0, statusFail, statusDone}, 64'h0);
    end
  endtask

  logic [31:0] specials [0:29] = '{
    32'hF000F, 32'h18002, 32'h1010C00, 32'h1010C01, 32'h1010C02, 32'h1010C03, 32'h1010C04,
    32'h1010C05, 32'h1020013, 32'h1020014, 32'hF0033, 32'hF0034, 32'h90012, 32'h90013,
    32'h90018, 32'h2020007, 32'h2020009, 32'h202000F, 32'h2013F00, 32'h2013F03, 32'h2013F07,
    32'h2013F08, 32'h2013EFF, 32'h1010C06, 32'h18003, 32'hF000E, 32'h90019, 32'h2020008,
    32'h1020012, 32'hF0035};

  task automatic randomRuns(input int n);
    for (int k = 0; k < n; k++) begin
      logic [31:0] a;
      logic [7:0]  be;
      bit wr, er;
      int lt;
      wr = $urandom_range(1, 0) == 1;
      er = $urandom_range(7, 0) == 0;
      lt = $urandom_range(3, 0);
      be = ($urandom_range(9, 0) == 0) ? 8'($urandom) : 8'hFF;
      if ($urandom_range(2, 0) == 0)
        a = fromIdx(specials[$urandom_range(29, 0)], curModeB, $urandom_range(1, 0) == 1);
      else
        a = {$urandom} & 32'h3FFF_FFF8;
      if ($urandom_range(15, 0) == 0) a[2:0] = 3'($urandom_range(7, 1));
      runOne(curModeB ? "R2" : "R1", wr, be, a, {$urandom, $urandom}, er, lt, 1'b1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    doReset(1'b0);
    check("R13", "reset hostReady", 64'(hostReady), 64'h1);
    check("R13", "reset dsReq", 64'(dsReq), 64'h0);
    check("R13", "reset respValid", 64'(hostRespValid), 64'h0);
    check("R12", "reset status", {62'h0, statusFail, statusDone}, 64'h0);

    // R1 / R4 forwarded accesses in mode A
    runOne("R1", 1'b0, 8'hFF, 32'h0001_23C8, 64'h0, 1'b0, 2, 1'b1);
    runOne("R4", 1'b1, 8'hFF, 32'h0000_4560, 64'h0102_0304_0506_0708, 1'b0, 0, 1'b1);
    runOne("R4", 1'b0, 8'hFF, 32'h0000_4560, 64'h0, 1'b0, 1, 1'b1);

    // R5 chip id
    runOne("R5", 1'b0, 8'hFF, fromIdx(32'hF000F, 1'b0, 1'b0), 64'h0, 1'b0, 0, 1'b1);
    runOne("R5", 1'b1, 8'hFF, fromIdx(32'hF000F, 1'b0, 1'b0), 64'hFFFF, 1'b0, 0, 1'b1);

    // R6 / R7 / R8 whitelist walk
    for (int i = 0; i < 30; i++) begin
      logic [31:0] ix;
      ix = specials[i];
      runOne(expZeroRd(ix) ? "R6" : "R8", 1'b0, 8'hFF, fromIdx(ix, 1'b0, 1'b0), 64'h0, 1'b0, 0, 1'b1);
      runOne(expDropWr(ix) ? "R7" : "R8", 1'b1, 8'hFF, fromIdx(ix, 1'b0, 1'b0), 64'hDEAD_0000 + 64'(i), 1'b0, 1, 1'b1);
    end

    // R9 malformed accesses
    runOne("R9", 1'b0, 8'h0F, 32'h0000_1000, 64'h0, 1'b0, 0, 1'b1);
    runOne("R9", 1'b1, 8'hFF, 32'h0000_1004, 64'h55, 1'b0, 0, 1'b1);

    // R10 downstream error
    runOne("R10", 1'b0, 8'hFF, 32'h0000_2000, 64'h0, 1'b1, 1, 1'b1);

    // R11 timeout edge
    cfgTimeout = 8'd5;
    runOne("R11", 1'b0, 8'hFF, 32'h0000_3000, 64'h0, 1'b0, 5, 1'b1);
    respOn = 1'b0;
    runOne("R11", 1'b0, 8'hFF, 32'h0000_3008, 64'h0, 1'b0, 0, 1'b1);
    respOn = 1'b1;
    cfgTimeout = 8'd20;

    // R12 stickiness and partial clear
    runOne("R12", 1'b0, 8'hFF, 32'h0000_2000, 64'h0, 1'b1, 0, 1'b0);
    runOne("R12", 1'b0, 8'hFF, 32'h0000_2008, 64'h0, 1'b0, 0, 1'b0);
    check("R12", "fail stays sticky", 64'(statusFail), 64'h1);
    clearStatus(2'b01);
    check("R12", "partial clear", {62'h0, statusFail, statusDone}, 64'h2);
    clearStatus(2'b10);
    check("R12", "fail cleared", {62'h0, statusFail, statusDone}, 64'h0);

    // R12 completion collides with clear: local read finishes two edges after request
    hostValid = 1'b1; hostWrite = 1'b0; hostByteEn = 8'hFF; hostAddr = fromIdx(32'h18002, 1'b0, 1'b0);
    @(negedge clk);
    hostValid = 1'b0; statusWe = 1'b1; statusClr = 2'b11;
    @(negedge clk);
    statusWe = 1'b0; statusClr = 2'b00;
    check("R12", "completion wins over clear", 64'(statusDone), 64'h1);
    check("R13", "respValid at collision", 64'(hostRespValid), 64'h1);
    @(negedge clk);
    clearStatus(2'b11);

    // R3 mode pin ignored after reset (mode A kept)
    cfgModeB = 1'b1;
    runOne("R3", 1'b0, 8'hFF, 32'h0012_34F8, 64'h0, 1'b0, 0, 1'b1);
    randomRuns(150);

    // mode B
    doReset(1'b1);
    runOne("R2", 1'b0, 8'hFF, 32'h0012_34F8, 64'h0, 1'b0, 0, 1'b1);
    runOne("R2", 1'b0, 8'hFF, fromIdx(32'hF000F, 1'b1, 1'b1), 64'h0, 1'b0, 0, 1'b1);
    runOne("R2", 1'b1, 8'hFF, fromIdx(32'h1010C04, 1'b1, 1'b1), 64'h77, 1'b0, 0, 1'b1);
    cfgModeB = 1'b0;
    runOne("R3", 1'b0, 8'hFF, 32'h0056_78B8, 64'h0, 1'b0, 1, 1'b1);
    for (int i = 0; i < 30; i++)
      runOne("R2", 1'b0, 8'hFF, fromIdx(specials[i], 1'b1, i[0]), 64'h0, 1'b0, 0, 1'b1);
    randomRuns(150);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule